// File: doc/BRIEF.md
# First-Fault Predicated Vector Word Loader

This block is a sequencing engine that fills a vector of 64-bit lanes from consecutive 32-bit words in memory. It works under a per-lane predicate and with first-fault semantics. A start pulse captures a 64-bit base address, a 64-bit element index, the predicate mask and the incoming first-fault bits (one per lane). The engine then visits the lanes in ascending order. For each active lane it issues one word read over a valid/ready request channel and waits for a registered response. That response carries the data and a fault flag. Each loaded word is sign-extended into its lane.

Only the earliest active lane may take a real fault. If it does, the engine stops and raises a one-cycle exception, and its visible outputs stay as they were. A fault on any later active lane is suppressed. It clears the first-fault bit of that lane and of every lane above it. A lane whose first-fault bit ends up 0 is written as zero, and so is every lane above such a lane. When the last lane is processed, the result vector and the updated first-fault bits appear together with a one-cycle done pulse.

The engine is meant to sit between an instruction pipeline and a load port. The caller's index register is never changed; the engine keeps its own running lane offset.

Top module: `ffld_top`

## Requirements
- R1: After reset `done_o`, `exc_o`, `req_valid_o` and `busy_o` are 0, and `result_o` and `ffr_o` are all zeros.
- R2: The read address for lane e is `base + 4*(index + e)`, computed modulo 2^64, so it wraps past the top of the address space. The offset advances for inactive lanes as well.
- R3: An active lane without a fault receives its 32-bit word in bits 31:0, and bit 31 is copied into bits 63:32 (lane e occupies `result_o[64e+63:64e]`).
- R4: A lane whose predicate bit is 0 issues no read, never faults and is written as zero.
- R5: A fault on the first active lane pulses `exc_o` for one cycle with no `done_o`, issues no further reads, and leaves `result_o` and `ffr_o` at their previous values.
- R6: A fault on any later active lane raises no exception. It forces `ffr_o` bit e and every higher bit to 0 whatever their predicate bits are, zeroes those lanes, and leaves lower bits equal to the incoming first-fault bits.
- R7: A lane whose first-fault bit is 0 (incoming or cleared) is written as zero, and so is every higher lane. Incoming first-fault bits pass to `ffr_o` unless a suppressed fault clears them.
- R8: Reads are issued in ascending lane order with at most one outstanding. `req_valid_o` and `req_addr_o` stay stable until `req_ready_i` is seen.
- R9: When the last lane completes, `done_o` is high for exactly one cycle, and `result_o` and `ffr_o` take their new values in that same cycle.
- R10: A start pulse while `busy_o` is high is ignored and does not disturb the run in progress.
- R11: With no predicate bit set the engine finishes without any read, `result_o` is all zeros and `ffr_o` equals the incoming first-fault bits.
- R12: Active lanes after a suppressed fault still issue their reads, so a run that does not abort issues exactly one read per active lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| base_i | input | 64 | Base byte address |
| index_i | input | 64 | Element index of lane 0 |
| pred_i | input | 4 | Predicate, one bit per lane |
| ffr_i | input | 4 | Incoming first-fault bits, one per lane |
| busy_o | output | 1 | Engine is running |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 64 | Read byte address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 32 | Read response word |
| rsp_fault_i | input | 1 | Read response fault flag |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | One-cycle exception pulse from the first active lane |
| result_o | output | 256 | Assembled result vector |
| ffr_o | output | 4 | Updated first-fault bits |

## Verification
The corner cases are the ones where a simpler engine would go wrong:
- **First-active-lane fault.** The fault is placed on lane 1 behind an inactive lane 0. A design that treated lane 0 as "first" would suppress the fault instead of raising the exception.
- **Later-lane fault.** A fault on a later lane, followed by an inactive lane and an active one, exposes three errors: a first-fault clear that skips inactive lanes, a zeroing that does not propagate upward, and an engine that stops issuing reads after suppression.
- **Incoming cleared bit.** An incoming first-fault bit already 0 must zero every lane above it while those lanes' bits pass through.
- **Address and handshake edges.** An index just below 2^64 checks the wrapping address and the counting of inactive lanes. Alternating back-pressure checks that requests are held. A stray start pulse mid-run must leave the result unchanged.

// File: rtl/ffld_pkg.sv
package ffld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LANE = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } ffld_state_e;

endpackage

// File: rtl/ffld_addr_gen.sv
module ffld_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int LANE_W = 2,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] elem_idx;

    always_comb begin
        elem_idx = index_i + ADDR_W'(lane_i);
        addr_o   = base_i + (elem_idx << SHIFT);
    end
endmodule

// File: rtl/ffld_lane_step.sv
module ffld_lane_step #(
    parameter int ELEM_W = 64,
    parameter int MEM_W  = 32
) (
    input  logic              active_i,
    input  logic              first_i,
    input  logic              fault_i,
    input  logic [MEM_W-1:0]  data_i,
    input  logic              ffr_bit_i,
    input  logic              faulted_i,
    input  logic              unknown_i,
    output logic              abort_o,
    output logic              ffr_bit_o,
    output logic              faulted_o,
    output logic              unknown_o,
    output logic [ELEM_W-1:0] lane_val_o
);
    localparam int EXT_W = ELEM_W - MEM_W;

    logic suppressed;

    always_comb begin
        abort_o    = active_i && first_i && fault_i;
        suppressed = active_i && !first_i && fault_i;
        faulted_o  = faulted_i || suppressed;
        ffr_bit_o  = ffr_bit_i && !faulted_o;
        unknown_o  = unknown_i || !ffr_bit_o;
        if (unknown_o || !active_i) begin
            lane_val_o = '0;
        end else begin
            lane_val_o = {{EXT_W{data_i[MEM_W-1]}}, data_i};
        end
    end
endmodule

// File: rtl/ffld_top.sv
module ffld_top
    import ffld_pkg::*;
#(
    parameter int VL     = 256,
    parameter int ELEM_W = 64,
    parameter int MEM_W  = 32,
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    index_i,
    input  logic [VL/ELEM_W-1:0] pred_i,
    input  logic [VL/ELEM_W-1:0] ffr_i,
    output logic                 busy_o,
    output logic                 req_valid_o,
    input  logic                 req_ready_i,
    output logic [ADDR_W-1:0]    req_addr_o,
    input  logic                 rsp_valid_i,
    input  logic [MEM_W-1:0]     rsp_data_i,
    input  logic                 rsp_fault_i,
    output logic                 done_o,
    output logic                 exc_o,
    output logic [VL-1:0]        result_o,
    output logic [VL/ELEM_W-1:0] ffr_o
);
    localparam int NL = VL / ELEM_W;
    localparam int LW = (NL > 1) ? $clog2(NL) : 1;
    localparam int WORD_BYTES = MEM_W / 8;
    localparam logic [LW-1:0] LAST_LANE = LW'(NL - 1);

    typedef struct packed {
        ffld_state_e                 state;
        logic [LW-1:0]               lane;
        logic [ADDR_W-1:0]           base;
        logic [ADDR_W-1:0]           index;
        logic [NL-1:0]               pred;
        logic [NL-1:0]               ffr_w;
        logic [NL-1:0][ELEM_W-1:0]   res_w;
        logic [NL-1:0][ELEM_W-1:0]   res_out;
        logic [NL-1:0]               ffr_out;
        logic                        first;
        logic                        faulted;
        logic                        unknown;
        logic                        done;
        logic                        exc;
    } regs_t;

    regs_t q, d;

    logic              step_active;
    logic              step_abort;
    logic              step_ffr_bit;
    logic              step_faulted;
    logic              step_unknown;
    logic [ELEM_W-1:0] step_val;
    logic              cur_pred;
    logic              cur_ffr;

    assign cur_pred    = q.pred[q.lane];
    assign cur_ffr     = q.ffr_w[q.lane];
    assign step_active = (q.state == ST_WAIT);

    ffld_addr_gen #(
        .ADDR_W     (ADDR_W),
        .LANE_W     (LW),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .base_i  (q.base),
        .index_i (q.index),
        .lane_i  (q.lane),
        .addr_o  (req_addr_o)
    );

    ffld_lane_step #(
        .ELEM_W (ELEM_W),
        .MEM_W  (MEM_W)
    ) u_step (
        .active_i   (step_active),
        .first_i    (q.first),
        .fault_i    (rsp_fault_i),
        .data_i     (rsp_data_i),
        .ffr_bit_i  (cur_ffr),
        .faulted_i  (q.faulted),
        .unknown_i  (q.unknown),
        .abort_o    (step_abort),
        .ffr_bit_o  (step_ffr_bit),
        .faulted_o  (step_faulted),
        .unknown_o  (step_unknown),
        .lane_val_o (step_val)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.exc  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state   = ST_LANE;
                    d.lane    = '0;
                    d.base    = base_i;
                    d.index   = index_i;
                    d.pred    = pred_i;
                    d.ffr_w   = ffr_i;
                    d.res_w   = '0;
                    d.first   = 1'b1;
                    d.faulted = 1'b0;
                    d.unknown = 1'b0;
                end
            end
            ST_LANE: begin
                if (cur_pred) begin
                    d.state = ST_REQ;
                end else begin
                    d.res_w[q.lane] = step_val;
                    d.ffr_w[q.lane] = step_ffr_bit;
                    d.faulted       = step_faulted;
                    d.unknown       = step_unknown;
                    if (q.lane == LAST_LANE) begin
                        d.state   = ST_IDLE;
                        d.done    = 1'b1;
                        d.res_out = d.res_w;
                        d.ffr_out = d.ffr_w;
                    end else begin
                        d.lane = q.lane + 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready_i) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (step_abort) begin
                        d.state = ST_IDLE;
                        d.exc   = 1'b1;
                    end else begin
                        d.first         = 1'b0;
                        d.res_w[q.lane] = step_val;
                        d.ffr_w[q.lane] = step_ffr_bit;
                        d.faulted       = step_faulted;
                        d.unknown       = step_unknown;
                        if (q.lane == LAST_LANE) begin
                            d.state   = ST_IDLE;
                            d.done    = 1'b1;
                            d.res_out = d.res_w;
                            d.ffr_out = d.ffr_w;
                        end else begin
                            d.lane  = q.lane + 1'b1;
                            d.state = ST_LANE;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.state != ST_IDLE);
    assign req_valid_o = (q.state == ST_REQ);
    assign done_o      = q.done;
    assign exc_o       = q.exc;
    assign result_o    = q.res_out;
    assign ffr_o       = q.ffr_out;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (!done_o && $stable(result_o) && $stable(ffr_o) && !req_valid_o));

    // R4
    inactive_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LANE && !cur_pred) |=> !req_valid_o);

    // R10
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(q.base) && $stable(q.index) && $stable(q.pred)));

    // R6
    suppress_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && rsp_valid_i && rsp_fault_i && !q.first) |=> (q.faulted && !exc_o));
endmodule

// File: tb/tb_ffld_top.sv
module tb_ffld_top;
    localparam int NL = 4;
    localparam int VW = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [63:0]     base_i = '0;
    logic [63:0]     index_i = '0;
    logic [NL-1:0]   pred_i = '0;
    logic [NL-1:0]   ffr_i = '0;
    logic            busy_o;
    logic            req_valid_o;
    logic            req_ready_i = 1'b1;
    logic [63:0]     req_addr_o;
    logic            rsp_valid_i = 1'b0;
    logic [31:0]     rsp_data_i = '0;
    logic            rsp_fault_i = 1'b0;
    logic            done_o;
    logic            exc_o;
    logic [VW-1:0]   result_o;
    logic [NL-1:0]   ffr_o;

    int checks = 0;
    int fails  = 0;

    int          ready_mode = 0;
    logic        fault_en = 1'b0;
    logic [63:0] fault_addr = '0;
    logic        acc_n = 1'b0;
    logic [63:0] acc_addr = '0;
    int          nreq = 0;
    logic [63:0] req_log [0:15];

    logic [VW-1:0] prev_res = '0;
    logic [NL-1:0] prev_ffr = '0;

    always #2 clk = ~clk;

    ffld_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .index_i(index_i), .pred_i(pred_i), .ffr_i(ffr_i), .busy_o(busy_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_fault_i(rsp_fault_i),
        .done_o(done_o), .exc_o(exc_o), .result_o(result_o), .ffr_o(ffr_o)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[33:2] * 32'h9E37_79B1;
    endfunction

    always @(negedge clk) begin
        acc_n <= req_valid_o && req_ready_i;
        acc_addr <= req_addr_o;
        if (req_valid_o && req_ready_i) begin
            if (nreq < 16) req_log[nreq] = req_addr_o;
            nreq = nreq + 1;
        end
    end

    always @(posedge clk) begin
        rsp_valid_i <= acc_n;
        rsp_data_i  <= mem_word(acc_addr);
        rsp_fault_i <= acc_n && fault_en && (acc_addr == fault_addr);
        if (ready_mode == 0) req_ready_i <= 1'b1;
        else req_ready_i <= ~req_ready_i;
    end

    task automatic chk(input logic ok, input string tag,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=completion");
        finish_run();
    end

    task automatic run(input logic [63:0] b, input logic [63:0] idx,
                       input logic [NL-1:0] p, input logic [NL-1:0] f,
                       input logic fen, input logic [63:0] faddr,
                       input int rmode, input logic restart, input string tag);
        logic [VW-1:0] e_res;
        logic [NL-1:0] e_ffr;
        logic [63:0]   e_addr [0:15];
        int            e_n;
        logic          e_exc, first, faulted, unk, flt, saw_done, saw_exc;
        logic [63:0]   a;
        logic [31:0]   w;
        // reference model built from the requirements
        e_res = '0; e_ffr = '0; e_n = 0; e_exc = 1'b0;
        first = 1'b1; faulted = 1'b0; unk = 1'b0;
        for (int e = 0; e < NL; e++) begin
            if (!e_exc) begin
                a = b + ((idx + 64'(e)) << 2);
                flt = 1'b0;
                if (p[e]) begin
                    e_addr[e_n] = a; e_n++;
                    if (fen && a == faddr) begin
                        if (first) e_exc = 1'b1;
                        else flt = 1'b1;
                    end
                    first = 1'b0;
                end
                faulted = faulted | flt;
                e_ffr[e] = f[e] & ~faulted;
                unk = unk | ~e_ffr[e];
                w = mem_word(a);
                if (p[e] && !unk) e_res[e*64 +: 64] = {{32{w[31]}}, w};
            end
        end
        if (e_exc) begin e_res = prev_res; e_ffr = prev_ffr; end

        @(negedge clk);
        ready_mode = rmode; fault_en = fen; fault_addr = faddr; nreq = 0;
        base_i = b; index_i = idx; pred_i = p; ffr_i = f; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        saw_done = 1'b0; saw_exc = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (restart && c == 3) begin
                base_i = b + 64'h1000; pred_i = ~p; ffr_i = ~f; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin saw_done = 1'b1; break; end
            if (exc_o) begin saw_exc = 1'b1; break; end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(saw_done == !e_exc, {tag, " R9 done seen"}, VW'(saw_done), VW'(!e_exc));
        chk(saw_exc == e_exc, {tag, " R5 exception seen"}, VW'(saw_exc), VW'(e_exc));
        chk(result_o == e_res, {tag, " R3 R6 R7 result"}, result_o, e_res);
        chk(ffr_o == e_ffr, {tag, " R6 R7 ffr"}, VW'(ffr_o), VW'(e_ffr));
        @(negedge clk);
        chk(!done_o && !exc_o, {tag, " R9 single-cycle pulse"},
            VW'({done_o, exc_o}), VW'(0));
        repeat (3) @(negedge clk);
        chk(nreq == e_n, {tag, " R12 R4 read count"}, VW'(nreq), VW'(e_n));
        for (int i = 0; i < e_n && i < nreq && i < 16; i++)
            chk(req_log[i] == e_addr[i], {tag, " R2 R8 read address order"},
                VW'(req_log[i]), VW'(e_addr[i]));
        prev_res = e_res; prev_ffr = e_ffr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done_o && !exc_o && !req_valid_o && !busy_o, "R1 control outputs idle",
            VW'({done_o, exc_o, req_valid_o, busy_o}), VW'(0));
        chk(result_o == '0 && ffr_o == '0, "R1 result and ffr cleared",
            result_o, VW'(ffr_o));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R8 all lanes active, no faults
        run(64'h0000_0000_8000_0000, 64'd5, 4'b1111, 4'b1111, 1'b0, '0, 0, 1'b0, "all_active");
        // R2 R4 mixed predicate, wrapping index, back-pressure
        run(64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFE, 4'b1010, 4'b1111,
            1'b0, '0, 1, 1'b0, "wrap_mixed");
        // R5 fault on first active lane (lane 1 behind inactive lane 0)
        run(64'h0000_0000_0000_2000, 64'd0, 4'b0110, 4'b1111,
            1'b1, 64'h0000_0000_0000_2004, 0, 1'b0, "first_fault");
        // R6 R12 suppressed fault on lane 1; lane 2 inactive; lane 3 still read
        run(64'h0000_0000_0000_3000, 64'd2, 4'b1011, 4'b1111,
            1'b1, 64'h0000_0000_0000_300C, 1, 1'b0, "later_fault");
        // R7 incoming ffr bit 1 clear
        run(64'h0000_0000_7FFF_0000, 64'd9, 4'b1111, 4'b1101, 1'b0, '0, 0, 1'b0, "ffr_in_zero");
        // R11 no active lanes
        run(64'h0000_0000_0000_4000, 64'd1, 4'b0000, 4'b1011, 1'b0, '0, 0, 1'b0, "none_active");
        // R10 stray start while busy
        run(64'h0000_0001_0000_0000, 64'd3, 4'b1101, 4'b1111, 1'b0, '0, 1, 1'b1, "busy_start");
        finish_run();
    end
endmodule